// File: doc/BRIEF.md
# Strap-Configured GPIO Pin Multiplexer

This block owns sixteen chip pins. Each pin is driven either by a general-purpose I/O port or by an alternate-function signal that comes from elsewhere in the chip. A per-pin select bit makes the choice. In GPIO mode, a direction bit decides whether the pin drives or listens, and an output latch supplies the driven value. A data read returns the pin state as GPIO software expects to see it.

The select register has no fixed reset value. While reset is held, every select bit follows a configuration strap input. The value present at the last clock edge before reset is released is the one that stays. A low strap gives all pins to GPIO, and a high strap gives all pins to their alternate functions. After reset, software can hand any subset of pins back and forth. For example, the upper address pins 15..10 can become GPIO while pins 9..8 stay with the address function.

Registers sit on a simple bus. Writes take a one-cycle strobe, and read data is combinational.

Top module: `strap_pinmux_port`

## Requirements
- R1: While `rst_n` is low, every select bit loads the `strap_alt` level. After release, the select register reads 0xFFFF for a high strap and 0x0000 for a low strap. Later strap changes have no effect.
- R2: After reset, the direction register (offset 0x08) and the output latch both read as zero. All pins are GPIO inputs or alternate, and no GPIO pin is driven.
- R3: `pad_out[n]` equals `alt_out[n]` when select bit n is 1, and equals latch bit n when select bit n is 0.
- R4: For a pin with select bit 0, `pad_oe[n]` equals direction bit n (1 = output).
- R5: For a pin with select bit 1, `pad_oe[n]` equals `alt_oe[n]`, whatever the direction bit holds.
- R6: Reading offset 0x0C returns the live `pad_in[n]` for pins with select 0 and direction 0. No clock edge is needed.
- R7: Reading offset 0x0C returns latch bit n for pins with select 0 and direction 1.
- R8: Reading offset 0x0C returns 0 in every bit whose select bit is 1.
- R9: Select bits act independently. With select = 0x03FF, pins 15..10 follow the GPIO latch while pins 9..8 follow `alt_out`.
- R10: Writes to offsets other than 0x04, 0x08 and 0x0C change no register. Reads from those offsets return zero.
- R11: A write strobed at a clock edge to 0x04 (select), 0x08 (direction) or 0x0C (latch) is visible from the next cycle. Reading 0x04 or 0x08 returns the stored value.
- R12: `alt_in[n]` carries `pad_in[n]` when select bit n is 1, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_alt | input | 1 | Configuration strap, sampled while reset is held |
| reg_addr | input | 8 | Register byte offset |
| reg_wr | input | 1 | Single-cycle write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Combinational read data |
| alt_out | input | 16 | Alternate-function output values |
| alt_oe | input | 16 | Alternate-function output enables |
| alt_in | output | 16 | Pad input delivered to alternate functions |
| pad_in | input | 16 | Pad input levels |
| pad_out | output | 16 | Pad output values |
| pad_oe | output | 16 | Pad output enables |

## Verification
The select register is the state that matters most. If a select bit is wrong, the fault shows up in the same cycle on four outputs at once: `pad_out`, `pad_oe`, `alt_in` and the data readback all take the other source for that pin. A strap that is captured wrongly is therefore visible on the first cycle after reset. A wrong direction or latch bit shows up only on pins in GPIO mode, through `pad_oe`, `pad_out` or the 0x0C readback. A write that reaches a register it should not is visible from the cycle after the strobe.

// File: rtl/pinmux_pkg.sv
// Package: shared register offsets and access decode type for the pin multiplexer.
// Assumes byte offsets fit in eight bits; the top module widens or narrows as needed.
package pinmux_pkg;

    localparam logic [7:0] OFF_SEL  = 8'h04;
    localparam logic [7:0] OFF_DIR  = 8'h08;
    localparam logic [7:0] OFF_DATA = 8'h0C;

    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_SEL  = 2'd1,
        ACC_DIR  = 2'd2,
        ACC_DATA = 2'd3
    } acc_kind_e;

endpackage

// File: rtl/pinmux_regfile.sv
// Module: pinmux_regfile
// Holds the select, direction and output-latch registers and decodes the offset.
// Assumes a synchronous active-low reset; select bits follow the strap during reset,
// so the level at the final reset edge is the one that remains after release.
module pinmux_regfile
    import pinmux_pkg::*;
#(
    parameter int N      = 16,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_alt,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [N-1:0]      reg_wdata,
    output acc_kind_e         acc_kind,
    output logic [N-1:0]      sel_q,
    output logic [N-1:0]      dir_q,
    output logic [N-1:0]      dout_q
);

    // Decode the byte offset into the register it addresses.
    always_comb begin
        if (reg_addr == ADDR_W'(OFF_SEL))
            acc_kind = ACC_SEL;
        else if (reg_addr == ADDR_W'(OFF_DIR))
            acc_kind = ACC_DIR;
        else if (reg_addr == ADDR_W'(OFF_DATA))
            acc_kind = ACC_DATA;
        else
            acc_kind = ACC_NONE;
    end

    // Select register: tracks the strap in reset, software-written afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_q <= {N{strap_alt}};
        else if (reg_wr && acc_kind == ACC_SEL)
            sel_q <= reg_wdata;
    end

    // Direction register: all inputs after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dir_q <= '0;
        else if (reg_wr && acc_kind == ACC_DIR)
            dir_q <= reg_wdata;
    end

    // Output latch: zero after reset, written through the data offset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dout_q <= '0;
        else if (reg_wr && acc_kind == ACC_DATA)
            dout_q <= reg_wdata;
    end

endmodule

// File: rtl/pinmux_pin.sv
// Module: pinmux_pin
// One pin slice: picks the pad driver and enable, gates the alternate input,
// and forms the GPIO readback bit. Purely combinational.
module pinmux_pin (
    input  logic sel,
    input  logic dir,
    input  logic dout,
    input  logic alt_out,
    input  logic alt_oe,
    input  logic pad_in,
    output logic pad_out,
    output logic pad_oe,
    output logic alt_in,
    output logic gpio_rd
);

    // Route output value and enable from the chosen owner of the pin.
    always_comb begin
        if (sel) begin
            pad_out = alt_out;
            pad_oe  = alt_oe;
        end else begin
            pad_out = dout;
            pad_oe  = dir;
        end
    end

    // Deliver the pad level to the alternate function only when it owns the pin.
    always_comb alt_in = sel & pad_in;

    // GPIO view of the pin: latch for outputs, live pad for inputs, zero if alternate.
    always_comb begin
        if (sel)
            gpio_rd = 1'b0;
        else if (dir)
            gpio_rd = dout;
        else
            gpio_rd = pad_in;
    end

endmodule

// File: rtl/pinmux_readback.sv
// Module: pinmux_readback
// Combinational read-data multiplexer; undefined offsets read zero.
module pinmux_readback
    import pinmux_pkg::*;
#(
    parameter int N = 16
) (
    input  acc_kind_e    acc_kind,
    input  logic [N-1:0] sel_q,
    input  logic [N-1:0] dir_q,
    input  logic [N-1:0] gpio_rd,
    output logic [N-1:0] reg_rdata
);

    // Select the register image addressed this cycle.
    always_comb begin
        unique case (acc_kind)
            ACC_SEL:  reg_rdata = sel_q;
            ACC_DIR:  reg_rdata = dir_q;
            ACC_DATA: reg_rdata = gpio_rd;
            default:  reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/strap_pinmux_port.sv
// Module: strap_pinmux_port
// Top of the strap-configured GPIO pin multiplexer. Wires the register file,
// one pin slice per pin, and the read multiplexer. Assumes alternate-function
// sources and pad electrical behaviour live outside this block.
module strap_pinmux_port
    import pinmux_pkg::*;
#(
    parameter int N      = 16,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_alt,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [N-1:0]      reg_wdata,
    output logic [N-1:0]      reg_rdata,
    input  logic [N-1:0]      alt_out,
    input  logic [N-1:0]      alt_oe,
    output logic [N-1:0]      alt_in,
    input  logic [N-1:0]      pad_in,
    output logic [N-1:0]      pad_out,
    output logic [N-1:0]      pad_oe
);

    acc_kind_e    acc_kind;
    logic [N-1:0] sel_q;
    logic [N-1:0] dir_q;
    logic [N-1:0] dout_q;
    logic [N-1:0] gpio_rd;

    pinmux_regfile #(.N(N), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .strap_alt (strap_alt),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .acc_kind  (acc_kind),
        .sel_q     (sel_q),
        .dir_q     (dir_q),
        .dout_q    (dout_q)
    );

    for (genvar g = 0; g < N; g++) begin : g_pin
        pinmux_pin u_pin (
            .sel     (sel_q[g]),
            .dir     (dir_q[g]),
            .dout    (dout_q[g]),
            .alt_out (alt_out[g]),
            .alt_oe  (alt_oe[g]),
            .pad_in  (pad_in[g]),
            .pad_out (pad_out[g]),
            .pad_oe  (pad_oe[g]),
            .alt_in  (alt_in[g]),
            .gpio_rd (gpio_rd[g])
        );
    end

    pinmux_readback #(.N(N)) u_rd (
        .acc_kind  (acc_kind),
        .sel_q     (sel_q),
        .dir_q     (dir_q),
        .gpio_rd   (gpio_rd),
        .reg_rdata (reg_rdata)
    );

endmodule

// File: rtl/pinmux_checker.sv
// Module: pinmux_checker
// Temporal checks on the pin multiplexer, bound to the top module.
module pinmux_checker
    import pinmux_pkg::*;
#(
    parameter int N      = 16,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              strap_alt,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr,
    input logic [N-1:0]      reg_wdata,
    input logic [N-1:0]      reg_rdata,
    input logic [N-1:0]      pad_oe,
    input logic [N-1:0]      alt_in,
    input logic [N-1:0]      sel_q,
    input logic [N-1:0]      dir_q,
    input logic [N-1:0]      dout_q
);

    logic undef_off;
    always_comb undef_off = (reg_addr != ADDR_W'(OFF_SEL)) &&
                            (reg_addr != ADDR_W'(OFF_DIR)) &&
                            (reg_addr != ADDR_W'(OFF_DATA));

    p_strap_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> sel_q == {N{$past(strap_alt)}});

    p_reset_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (dir_q == '0 && dout_q == '0));

    p_gpio_oe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe ^ dir_q) & ~sel_q) == '0);

    p_alt_read_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_W'(OFF_DATA)) |-> (reg_rdata & sel_q) == '0);

    p_undef_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && undef_off) |=> ($stable(sel_q) && $stable(dir_q) && $stable(dout_q)));

    p_undef_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        undef_off |-> reg_rdata == '0);

    p_sel_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_W'(OFF_SEL)) |=> sel_q == $past(reg_wdata));

    p_alt_in_gate_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (alt_in & ~sel_q) == '0);

endmodule

bind strap_pinmux_port pinmux_checker #(.N(N), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .strap_alt (strap_alt),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .pad_oe    (pad_oe),
    .alt_in    (alt_in),
    .sel_q     (sel_q),
    .dir_q     (dir_q),
    .dout_q    (dout_q)
);

// File: tb/tb_strap_pinmux_port.sv
// Bench for strap_pinmux_port: vector table walk, then directed reset and corner tests.
module tb_strap_pinmux_port;

    localparam int  N       = 16;
    localparam int  ADDR_W  = 8;
    localparam time CLK_P   = 8ns;
    localparam logic [7:0] A_SEL  = 8'h04;
    localparam logic [7:0] A_DIR  = 8'h08;
    localparam logic [7:0] A_DATA = 8'h0C;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              strap_alt = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic              reg_wr = 1'b0;
    logic [N-1:0]      reg_wdata = '0;
    logic [N-1:0]      reg_rdata;
    logic [N-1:0]      alt_out = '0;
    logic [N-1:0]      alt_oe = '0;
    logic [N-1:0]      alt_in;
    logic [N-1:0]      pad_in = '0;
    logic [N-1:0]      pad_out;
    logic [N-1:0]      pad_oe;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 0;

    always #(CLK_P / 2) clk = ~clk;

    strap_pinmux_port #(.N(N), .ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst_n(rst_n), .strap_alt(strap_alt),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .alt_out(alt_out), .alt_oe(alt_oe),
        .alt_in(alt_in), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    // Fields per row: select, direction, latch, pad_in, alt_out, alt_oe.
    localparam logic [95:0] VECS [0:5] = '{
        {16'h0000, 16'hFFFF, 16'hA5A5, 16'h1234, 16'hFFFF, 16'hFFFF},
        {16'h0000, 16'h0000, 16'hFFFF, 16'hC3C3, 16'h0000, 16'h0000},
        {16'hFFFF, 16'hFFFF, 16'hFFFF, 16'h5A5A, 16'h0F0F, 16'hF0F0},
        {16'h00FF, 16'h0F0F, 16'h3C3C, 16'h9999, 16'h6666, 16'hAAAA},
        {16'h03FF, 16'hFFFF, 16'hFFFF, 16'h0000, 16'h0000, 16'h0300},
        {16'h8001, 16'h7FFE, 16'h1248, 16'hFFFF, 16'h8001, 16'h0001}
    };

    task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [N-1:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
        reg_addr  = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [N-1:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic do_reset(input logic s);
        @(negedge clk);
        rst_n     = 1'b0;
        strap_alt = s;
        repeat (3) @(negedge clk);
        rst_n     = 1'b1;
        strap_alt = ~s;
        #1;
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] r;
        logic [N-1:0] s, d, q, pin, ao, ae;

        // Reset with low strap: all GPIO inputs, nothing driven.
        do_reset(1'b0);
        rd(A_SEL, r);  chk("R1 strap low select", r, 16'h0000);
        rd(A_DIR, r);  chk("R2 direction after reset", r, 16'h0000);
        chk("R2 no pad driven after reset", pad_oe, 16'h0000);
        chk("R2 latch zero on pad_out", pad_out, 16'h0000);
        @(negedge clk);
        rd(A_SEL, r);  chk("R1 strap change after release ignored", r, 16'h0000);

        // Vector table walk.
        for (int i = 0; i < 6; i++) begin
            {s, d, q, pin, ao, ae} = VECS[i];
            wr(A_SEL, s);
            wr(A_DIR, d);
            wr(A_DATA, q);
            pad_in  = pin;
            alt_out = ao;
            alt_oe  = ae;
            rd(A_DATA, r);
            chk($sformatf("R3 pad_out vec%0d", i), pad_out, (s & ao) | (~s & q));
            chk($sformatf("R4 R5 pad_oe vec%0d", i), pad_oe, (s & ae) | (~s & d));
            chk($sformatf("R6 R7 R8 readback vec%0d", i), r, ~s & ((d & q) | (~d & pin)));
            chk($sformatf("R12 alt_in vec%0d", i), alt_in, s & pin);
        end

        // R9: upper six pins to GPIO, pins 9..8 stay alternate.
        wr(A_SEL, 16'h03FF);
        wr(A_DIR, 16'hFC00);
        wr(A_DATA, 16'hA800);
        alt_out = 16'h0200;
        alt_oe  = 16'h0300;
        #1;
        chk("R9 upper pins from latch", pad_out & 16'hFC00, 16'hA800);
        chk("R9 pins 9..8 from alternate", pad_out & 16'h0300, 16'h0200);
        chk("R9 enables split", pad_oe & 16'hFF00, 16'hFF00);

        // R6 live input readback, no clock edge in between.
        wr(A_SEL, 16'h0000);
        wr(A_DIR, 16'h00FF);
        wr(A_DATA, 16'hABCD);
        pad_in = 16'h1111;
        rd(A_DATA, r); chk("R6 R7 mixed readback", r, 16'h11CD);
        pad_in = 16'h2222;
        rd(A_DATA, r); chk("R6 live pad change", r, 16'h22CD);

        // R11 readback of written registers.
        wr(A_DIR, 16'h1234);
        rd(A_DIR, r);  chk("R11 direction readback", r, 16'h1234);
        wr(A_SEL, 16'h5A0F);
        rd(A_SEL, r);  chk("R11 select readback", r, 16'h5A0F);

        // R10 undefined offsets.
        wr(8'h00, 16'hFFFF);
        wr(8'h06, 16'hFFFF);
        wr(8'h10, 16'hFFFF);
        rd(A_SEL, r);  chk("R10 select untouched", r, 16'h5A0F);
        rd(A_DIR, r);  chk("R10 direction untouched", r, 16'h1234);
        wr(A_SEL, 16'h0000);
        wr(A_DIR, 16'hFFFF);
        rd(A_DATA, r); chk("R10 latch untouched", r, 16'hABCD);
        rd(8'h10, r);  chk("R10 undefined read zero", r, 16'h0000);
        rd(8'h00, r);  chk("R10 offset zero reads zero", r, 16'h0000);

        // Reset with high strap: every pin alternate, latch and direction cleared.
        alt_oe  = 16'h00F0;
        alt_out = 16'h0F00;
        pad_in  = 16'hFFFF;
        do_reset(1'b1);
        rd(A_SEL, r);  chk("R1 strap high select", r, 16'hFFFF);
        rd(A_DATA, r); chk("R8 all alternate reads zero", r, 16'h0000);
        chk("R5 enables from alternate", pad_oe, 16'h00F0);
        chk("R12 alt_in after high strap", alt_in, 16'hFFFF);
        wr(A_SEL, 16'h0000);
        rd(A_DIR, r);  chk("R2 direction cleared by reset", r, 16'h0000);
        wr(A_DIR, 16'hFFFF);
        chk("R2 latch cleared by reset", pad_out, 16'h0000);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule